// File: doc/BRIEF.md
# Interleaved PCM Bus Slot Controller

This block attaches one framer port to a serial PCM backplane bus that up to eight ports share by channel interleaving. A frame lasts one 125 µs period and holds 32 channels for each device on the bus. Whole 8-bit channel slots are handed out in rotation: slot 0 goes to the first device, slot 1 to the second, and so on. Once every device has had a slot, the rotation starts again with the first device. The port therefore owns every N-th slot of the frame, where N is the device count that the selected bus rate implies.

An 8-bit control word sets the interleave enable, the bus rate (1, 2, 4 or 8 devices) and the port's position on the bus. During its own slots the block drives the transmit line from a byte-wide elastic store read port and captures the receive line into bytes that it writes back through the elastic store interface. A frame sync pulse aligns the slot and bit counters. While interleaving is on, the transmit frame sync output follows the receive frame sync and an external transmit sync input has no effect. The transmit clock source choice is passed through as a select flag.

Top module: `pcm_ilv_slot_ctl`

## Requirements
- R1: The control field in bits 5:4 selects the device count N. Code 00 gives 1, 01 gives 2, 10 gives 4 and 11 gives 8. A frame is 32×N byte slots of 8 bus clock cycles each. Without a frame sync the slot count wraps to slot 0 after the last slot.
- R2: With interleave enabled, the port owns slot s exactly when s mod N equals the position field in bits 2:0. A position greater than or equal to N owns no slot.
- R3: With the interleave enable in bit 3 at 0, the port runs alone. N is 1 and every slot is owned, whatever the rate and position fields hold.
- R4: During owned slots bus_txd_oe is 1 and bus_txd carries es_rd_data MSB first, bit 7 in the first cycle of the slot. Outside owned slots bus_txd_oe and bus_txd are 0.
- R5: es_rd_req is 1 for exactly one cycle per owned slot, in its last bit cycle. This pops the byte just sent.
- R6: bus_rxd is sampled MSB first during the 8 cycles of each owned slot. In the following cycle es_wr_vld is 1 for one cycle with the assembled byte on es_wr_data.
- R7: fsync_rx high in a cycle makes the next cycle bit 0 of slot 0, including when the pulse arrives mid-frame.
- R8: After reset and before the first fsync_rx, the port drives nothing, reads nothing and captures nothing.
- R9: The enable, rate and position fields take effect only at an fsync_rx cycle. Changes between frame syncs do not alter slot ownership until the next one.
- R10: fsync_tx equals fsync_rx while control bit 3 is 1. Otherwise it equals fsync_tx_ext.
- R11: txclk_sys_sel follows control bit 6. Bit 7 has no effect on any output.
- R12: While rst_n is low, bus_txd_oe, es_rd_req, es_wr_vld and es_wr_data are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctrl_reg | input | 8 | Control word: bit 6 clock select, 5:4 rate, 3 enable, 2:0 position |
| fsync_rx | input | 1 | Receive frame sync pulse |
| fsync_tx_ext | input | 1 | External transmit frame sync |
| bus_rxd | input | 1 | Serial receive data from the bus |
| es_rd_data | input | 8 | Head byte of the elastic store (first-word-fall-through) |
| es_rd_req | output | 1 | Pop strobe to the elastic store |
| es_wr_data | output | 8 | Captured channel byte |
| es_wr_vld | output | 1 | Captured byte valid |
| bus_txd | output | 1 | Serial transmit data |
| bus_txd_oe | output | 1 | Transmit drive-enable |
| fsync_tx | output | 1 | Transmit frame sync |
| txclk_sys_sel | output | 1 | Transmit clock taken from the system bus clock |

## Verification
Ownership is tried with the port alone, at every rate with positions at the low and high ends of the rotation, and with positions beyond the device count. These runs tell a wrong modulo or mask apart from a wrong range test. Random control words per frame, with the unused bit and the clock select toggled, cover the combinations the directed runs miss. Further runs free-run through a frame wrap, pulse the frame sync mid-frame, and rewrite the control word mid-frame. These separate counter wrap, realignment and configuration timing. Random receive bits and store bytes make any bit-order or off-by-one-cycle error show up as a data mismatch.

// File: rtl/ilv_pkg.sv
package ilv_pkg;

  localparam int RATE_W = 2;
  localparam int POS_W  = 3;
  localparam int MAX_DEV = 1 << ((1 << RATE_W) - 1);

  typedef struct packed {
    logic               rsvd;
    logic               txclk_sys;
    logic [RATE_W-1:0]  rate;
    logic               ilv_en;
    logic [POS_W-1:0]   pos;
  } ilv_ctrl_t;

endpackage

// File: rtl/ilv_rst_sync.sv
module ilv_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_sync_n = sync_q[1];

endmodule

// File: rtl/ilv_cfg_latch.sv
module ilv_cfg_latch
  import ilv_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fsync,
  input  logic              ctrl_en,
  input  logic [RATE_W-1:0] ctrl_rate,
  input  logic [POS_W-1:0]  ctrl_pos,
  output logic              locked,
  output logic              en_act,
  output logic [RATE_W-1:0] lg_dev,
  output logic [POS_W-1:0]  pos_eff,
  output logic              pos_valid
);

  logic              en_q,     en_d;
  logic [RATE_W-1:0] rate_q,   rate_d;
  logic [POS_W-1:0]  pos_q,    pos_d;
  logic              locked_q, locked_d;
  logic [POS_W:0]    ndev;

  // next-state: configuration is captured only on a frame sync
  always_comb begin
    en_d     = en_q;
    rate_d   = rate_q;
    pos_d    = pos_q;
    locked_d = locked_q;
    if (fsync) begin
      en_d     = ctrl_en;
      rate_d   = ctrl_rate;
      pos_d    = ctrl_pos;
      locked_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q     <= 1'b0;
      rate_q   <= '0;
      pos_q    <= '0;
      locked_q <= 1'b0;
    end else begin
      en_q     <= en_d;
      rate_q   <= rate_d;
      pos_q    <= pos_d;
      locked_q <= locked_d;
    end
  end

  assign locked    = locked_q;
  assign en_act    = en_q;
  assign lg_dev    = en_q ? rate_q : '0;
  assign pos_eff   = en_q ? pos_q  : '0;
  assign ndev      = (POS_W+1)'(1) << lg_dev;
  assign pos_valid = ({1'b0, pos_eff} < ndev);

  assert_cfg_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !fsync |=> ($stable(en_q) && $stable(rate_q) && $stable(pos_q)));

  assert_lock_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    locked_q |=> locked_q);

endmodule

// File: rtl/ilv_slot_timer.sv
module ilv_slot_timer
  import ilv_pkg::*;
#(
  parameter int CH_PER_DEV = 32,
  parameter int BYTE_W     = 8,
  parameter int SLOT_W     = 8,
  parameter int BIT_W      = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fsync,
  input  logic [RATE_W-1:0] lg_dev,
  input  logic [POS_W-1:0]  pos_eff,
  input  logic              pos_valid,
  output logic [SLOT_W-1:0] slot_q,
  output logic [BIT_W-1:0]  bit_q,
  output logic              own
);

  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(BYTE_W - 1);

  logic [SLOT_W-1:0] slot_d;
  logic [BIT_W-1:0]  bit_d;
  logic [SLOT_W:0]   frame_slots;
  logic              last_slot;
  logic [POS_W:0]    ndev;
  logic [POS_W-1:0]  dev_mask;
  logic [POS_W-1:0]  dev_idx;

  assign frame_slots = (SLOT_W+1)'(CH_PER_DEV) << lg_dev;
  assign last_slot   = ({1'b0, slot_q} == (frame_slots - 1'b1));

  always_comb begin
    slot_d = slot_q;
    bit_d  = bit_q;
    if (fsync) begin
      slot_d = '0;
      bit_d  = '0;
    end else if (bit_q == LAST_BIT) begin
      bit_d  = '0;
      slot_d = last_slot ? '0 : slot_q + 1'b1;
    end else begin
      bit_d  = bit_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_q <= '0;
      bit_q  <= '0;
    end else begin
      slot_q <= slot_d;
      bit_q  <= bit_d;
    end
  end

  // slot-to-device decode: low bits of the slot index, masked by N-1
  assign ndev     = (POS_W+1)'(1) << lg_dev;
  assign dev_mask = ndev[POS_W-1:0] - 1'b1;
  assign dev_idx  = slot_q[POS_W-1:0] & dev_mask;
  assign own      = pos_valid && (dev_idx == pos_eff);

  assert_slot_in_frame_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ({1'b0, slot_q} < frame_slots));

  assert_slot_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!fsync && bit_q == LAST_BIT && !last_slot) |=> (slot_q == $past(slot_q) + 1'b1));

  assert_sync_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fsync |=> (slot_q == '0 && bit_q == '0));

endmodule

// File: rtl/ilv_tx_slot.sv
module ilv_tx_slot #(
  parameter int BYTE_W = 8,
  parameter int BIT_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              own_act,
  input  logic [BIT_W-1:0]  bit_q,
  input  logic [BYTE_W-1:0] es_rd_data,
  output logic              txd,
  output logic              txd_oe,
  output logic              rd_req
);

  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(BYTE_W - 1);

  logic [BIT_W-1:0] sel_idx;

  assign sel_idx = LAST_BIT - bit_q;
  assign txd_oe  = own_act;
  assign txd     = own_act ? es_rd_data[sel_idx] : 1'b0;
  assign rd_req  = own_act && (bit_q == LAST_BIT);

  assert_quiet_line_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !txd_oe |-> !txd);

  assert_single_pop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> !rd_req);

  assert_pop_in_slot_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |-> txd_oe);

endmodule

// File: rtl/ilv_rx_slot.sv
module ilv_rx_slot #(
  parameter int BYTE_W = 8,
  parameter int BIT_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              own_act,
  input  logic [BIT_W-1:0]  bit_q,
  input  logic              rxd,
  output logic [BYTE_W-1:0] wr_data,
  output logic              wr_vld
);

  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(BYTE_W - 1);

  logic [BYTE_W-1:0] sh_q,   sh_d;
  logic [BYTE_W-1:0] data_q, data_d;
  logic              vld_q,  vld_d;
  logic              sh_en;

  assign sh_en = own_act;

  always_comb begin
    sh_d   = sh_q;
    data_d = data_q;
    vld_d  = 1'b0;
    if (sh_en) begin
      sh_d = {sh_q[BYTE_W-2:0], rxd};
      if (bit_q == LAST_BIT) begin
        data_d = {sh_q[BYTE_W-2:0], rxd};
        vld_d  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      data_q <= '0;
      vld_q  <= 1'b0;
    end else begin
      sh_q   <= sh_d;
      data_q <= data_d;
      vld_q  <= vld_d;
    end
  end

  assign wr_data = data_q;
  assign wr_vld  = vld_q;

  assert_wr_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_vld |=> !wr_vld);

  assert_wr_after_slot_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_vld |-> $past(own_act));

endmodule

// File: rtl/pcm_ilv_slot_ctl.sv
module pcm_ilv_slot_ctl
  import ilv_pkg::*;
#(
  parameter int CH_PER_DEV = 32,
  parameter int BYTE_W     = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [7:0]        ctrl_reg,
  input  logic              fsync_rx,
  input  logic              fsync_tx_ext,
  input  logic              bus_rxd,
  input  logic [BYTE_W-1:0] es_rd_data,
  output logic              es_rd_req,
  output logic [BYTE_W-1:0] es_wr_data,
  output logic              es_wr_vld,
  output logic              bus_txd,
  output logic              bus_txd_oe,
  output logic              fsync_tx,
  output logic              txclk_sys_sel
);

  localparam int SLOT_W = $clog2(CH_PER_DEV * MAX_DEV);
  localparam int BIT_W  = $clog2(BYTE_W);

  ilv_ctrl_t         ctrl;
  logic              ctrl_unused;
  logic              rst_sync_n;
  logic              locked;
  logic              en_act;
  logic [RATE_W-1:0] lg_dev;
  logic [POS_W-1:0]  pos_eff;
  logic              pos_valid;
  logic [SLOT_W-1:0] slot_q;
  logic [BIT_W-1:0]  bit_q;
  logic              own;
  logic              own_act;

  assign ctrl        = ilv_ctrl_t'(ctrl_reg);
  assign ctrl_unused = ctrl.rsvd;

  ilv_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  ilv_cfg_latch u_cfg (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .fsync     (fsync_rx),
    .ctrl_en   (ctrl.ilv_en),
    .ctrl_rate (ctrl.rate),
    .ctrl_pos  (ctrl.pos),
    .locked    (locked),
    .en_act    (en_act),
    .lg_dev    (lg_dev),
    .pos_eff   (pos_eff),
    .pos_valid (pos_valid)
  );

  ilv_slot_timer #(
    .CH_PER_DEV (CH_PER_DEV),
    .BYTE_W     (BYTE_W),
    .SLOT_W     (SLOT_W),
    .BIT_W      (BIT_W)
  ) u_timer (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .fsync     (fsync_rx),
    .lg_dev    (lg_dev),
    .pos_eff   (pos_eff),
    .pos_valid (pos_valid),
    .slot_q    (slot_q),
    .bit_q     (bit_q),
    .own       (own)
  );

  assign own_act = locked && own;

  ilv_tx_slot #(
    .BYTE_W (BYTE_W),
    .BIT_W  (BIT_W)
  ) u_tx (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .own_act    (own_act),
    .bit_q      (bit_q),
    .es_rd_data (es_rd_data),
    .txd        (bus_txd),
    .txd_oe     (bus_txd_oe),
    .rd_req     (es_rd_req)
  );

  ilv_rx_slot #(
    .BYTE_W (BYTE_W),
    .BIT_W  (BIT_W)
  ) u_rx (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .own_act (own_act),
    .bit_q   (bit_q),
    .rxd     (bus_rxd),
    .wr_data (es_wr_data),
    .wr_vld  (es_wr_vld)
  );

  assign fsync_tx      = ctrl.ilv_en ? fsync_rx : fsync_tx_ext;
  assign txclk_sys_sel = ctrl.txclk_sys;

  assert_idle_unlocked_R8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !locked |-> (!bus_txd_oe && !es_rd_req && !es_wr_vld));

  assert_solo_all_slots_R3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (locked && !en_act) |-> bus_txd_oe);

  assert_no_slot_out_of_range_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !pos_valid |-> !bus_txd_oe);

endmodule

// File: tb/test_pcm_ilv_slot_ctl.sv
module test_pcm_ilv_slot_ctl;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] ctrl_reg;
  logic       fsync_rx;
  logic       fsync_tx_ext;
  logic       bus_rxd;
  logic [7:0] es_rd_data;
  logic       es_rd_req;
  logic [7:0] es_wr_data;
  logic       es_wr_vld;
  logic       bus_txd;
  logic       bus_txd_oe;
  logic       fsync_tx;
  logic       txclk_sys_sel;

  always #2 clk = ~clk;

  pcm_ilv_slot_ctl i_pcm_ilv_slot_ctl (
    .clk           (clk),
    .rst_n         (rst_n),
    .ctrl_reg      (ctrl_reg),
    .fsync_rx      (fsync_rx),
    .fsync_tx_ext  (fsync_tx_ext),
    .bus_rxd       (bus_rxd),
    .es_rd_data    (es_rd_data),
    .es_rd_req     (es_rd_req),
    .es_wr_data    (es_wr_data),
    .es_wr_vld     (es_wr_vld),
    .bus_txd       (bus_txd),
    .bus_txd_oe    (bus_txd_oe),
    .fsync_tx      (fsync_tx),
    .txclk_sys_sel (txclk_sys_sel)
  );

  int checks = 0;
  int errors = 0;

  // reference model state, kept from the requirements
  int         m_slot = 0;
  int         m_bit = 0;
  bit         m_locked = 0;
  bit         m_en = 0;
  int         m_rate = 0;
  int         m_pos = 0;
  logic [7:0] m_sh = '0;
  bit         m_wr_vld = 0;
  logic [7:0] m_wr_data = '0;
  bit         pop_pending = 0;

  function automatic int dev_count(bit en, int rate);
    return en ? (1 << rate) : 1;
  endfunction

  function automatic bit model_owns();
    int n;
    int p;
    n = dev_count(m_en, m_rate);
    p = m_en ? m_pos : 0;
    return m_locked && (p < n) && ((m_slot % n) == p);
  endfunction

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d (slot %0d bit %0d)",
               tag, what, act, exp, m_slot, m_bit);
    end
  endtask

  // one bus cycle: drive just after a negedge, check, then advance the model
  task automatic cyc(bit fs, string tag);
    bit own;
    int exp_txd;
    fsync_rx     = fs;
    bus_rxd      = 1'($urandom);
    fsync_tx_ext = 1'($urandom);
    if (pop_pending) begin
      es_rd_data  = 8'($urandom);
      pop_pending = 0;
    end
    #1;
    own     = model_owns();
    exp_txd = own ? int'(es_rd_data[7 - m_bit]) : 0;
    chk(tag,   "oe",       int'(bus_txd_oe), int'(own));
    chk("R4",  "txd",      int'(bus_txd), exp_txd);
    chk("R5",  "rd_req",   int'(es_rd_req), int'(own && m_bit == 7));
    chk("R6",  "wr_vld",   int'(es_wr_vld), int'(m_wr_vld));
    if (m_wr_vld) chk("R6", "wr_data", int'(es_wr_data), int'(m_wr_data));
    chk("R10", "fsync_tx", int'(fsync_tx),
        ctrl_reg[3] ? int'(fs) : int'(fsync_tx_ext));
    chk("R11", "txclk_sel", int'(txclk_sys_sel), int'(ctrl_reg[6]));
    // model update at the coming edge
    if (own) m_sh = {m_sh[6:0], bus_rxd};
    m_wr_vld = own && (m_bit == 7);
    if (m_wr_vld) begin
      m_wr_data   = m_sh;
      pop_pending = 1;
    end
    if (fs) begin
      m_slot   = 0;
      m_bit    = 0;
      m_locked = 1;
      m_en     = ctrl_reg[3];
      m_rate   = int'(ctrl_reg[5:4]);
      m_pos    = int'(ctrl_reg[2:0]);
    end else if (m_bit == 7) begin
      m_bit  = 0;
      m_slot = (m_slot == 32 * dev_count(m_en, m_rate) - 1) ? 0 : m_slot + 1;
    end else begin
      m_bit++;
    end
    @(negedge clk);
  endtask

  task automatic frames(logic [7:0] c, int nfr, string tag);
    int len;
    ctrl_reg = c;
    len = 32 * 8 * dev_count(c[3], int'(c[5:4]));
    for (int f = 0; f < nfr; f++) begin
      for (int i = 0; i < len; i++) cyc(i == 0, tag);
    end
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd5180));
    rst_n        = 1'b0;
    ctrl_reg     = 8'h00;
    fsync_rx     = 1'b0;
    fsync_tx_ext = 1'b0;
    bus_rxd      = 1'b0;
    es_rd_data   = 8'hA5;
    repeat (3) @(negedge clk);
    #1;
    // R12: reset state
    chk("R12", "oe",      int'(bus_txd_oe), 0);
    chk("R12", "rd_req",  int'(es_rd_req), 0);
    chk("R12", "wr_vld",  int'(es_wr_vld), 0);
    chk("R12", "wr_data", int'(es_wr_data), 0);
    @(negedge clk);
    rst_n = 1'b1;
    // R8: no activity before the first frame sync
    for (int i = 0; i < 40; i++) cyc(1'b0, "R8");

    // R3: standalone, rate and position ignored
    frames(8'h00, 2, "R3");
    frames(8'h37, 1, "R3");

    // R2: ownership at each rate, low and high positions
    frames(8'h18, 1, "R2");
    frames(8'h19, 2, "R2");
    frames(8'h2B, 1, "R2");
    frames(8'h3D, 1, "R2");
    frames(8'h3F, 1, "R2");
    frames(8'h38, 1, "R2");
    // R2: positions beyond the device count
    frames(8'h0A, 1, "R2");
    frames(8'h1C, 1, "R2");
    // R11: unused bit and clock select set
    frames(8'hFF, 1, "R11");
    frames(8'h4A, 1, "R11");

    // R1: free-running wrap over two frames of four devices
    ctrl_reg = 8'h2A;
    cyc(1'b1, "R1");
    for (int i = 0; i < 2 * 1024 + 37; i++) cyc(1'b0, "R1");

    // R7: mid-frame realignment
    ctrl_reg = 8'h19;
    cyc(1'b1, "R7");
    for (int i = 0; i < 299; i++) cyc(1'b0, "R7");
    cyc(1'b1, "R7");
    for (int i = 0; i < 1100; i++) cyc(1'b0, "R7");

    // R9: control change mid-frame waits for the next sync
    ctrl_reg = 8'h3A;
    cyc(1'b1, "R9");
    for (int i = 0; i < 700; i++) cyc(1'b0, "R9");
    ctrl_reg = 8'h1D;
    for (int i = 0; i < 1347; i++) cyc(1'b0, "R9");
    ctrl_reg = 8'h11;
    for (int i = 0; i < 300; i++) cyc(1'b0, "R9");
    cyc(1'b1, "R9");
    for (int i = 0; i < 600; i++) cyc(1'b0, "R9");

    // R2: random control words, one frame each
    for (int k = 0; k < 20; k++) frames(8'($urandom), 1, "R2");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule